// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block sits between interrupt sources and a small core model. It accepts a non-maskable request, a hard-fault request and a parameterised set of external level-sensitive interrupt lines. For each source it holds a pending bit and an active bit. From the sources that are pending, eligible and not yet active, it picks the one with the most urgent priority. It raises a request toward the core only when that source outranks the current execution priority. The current execution priority is the most urgent priority among the active handlers, or an idle level when no handler is active.

The core takes a request by pulsing an acknowledge. That marks the source active and clears its pending bit. The core pulses a handler-return strobe when the running handler finishes. Because the active bits record every nested level, a return drops straight to the next most urgent active handler. If an eligible request is waiting at that moment, it is offered at once. Taking it in the cycle after the return counts as a tail-chain.

A byte-wide register port sets the per-line priority and the enable bit, sets or clears pending bits, and sets a base-priority mask. Priorities are four bits wide and live in the upper nibble of the byte.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, no source is pending or active, `irq_req` and `tail_chain` are low, and every priority, control and mask register reads zero.
- R2: The register port decodes `reg_addr[8:7]` as follows: 0 = priority of line `reg_addr[6:0]`, 1 = control of that line, 2 = base-priority mask. A priority or mask write keeps only `wdata[7:4]`, so bits [3:0] always read back as zero.
- R3: When external line n is held high while its enable bit is set, its pending bit is set on the next edge and it requests vector 16+n. A line held high while disabled leaves the pending bit clear.
- R4: The non-maskable request uses vector 2 and the hard-fault request uses vector 3. The non-maskable request outranks the hard fault, and both outrank every external line. A hard fault is not taken while a non-maskable handler is active.
- R5: Among eligible pending external lines, the numerically lowest priority wins. When priorities are equal, the lowest vector number wins.
- R6: A pending source raises `irq_req` only when its priority is strictly lower in number than the current execution priority. An equal priority does not preempt.
- R7: A nonzero mask value m blocks every external line whose priority is m or more. A mask of zero blocks nothing. The non-maskable and hard-fault requests are never masked.
- R8: An edge with `irq_req` and `irq_ack` both high makes the offered source active and clears its pending bit. An `irq_ack` while `irq_req` is low changes nothing.
- R9: A pulse on `exc_return` clears the active bit of the most urgent active source. The earlier nested levels stay active and set the new execution priority.
- R10: `tail_chain` is high for exactly one cycle, on the cycle after an acknowledge edge that directly follows an `exc_return` edge. An acknowledge with no return just before it leaves `tail_chain` low.
- R11: In the control byte, bit 0 is enable (read/write), bit 1 is pending (a write sets or clears it), bit 2 is active (read-only), and bits 7:3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| fault_req | input | 1 | Hard-fault request pulse |
| ext_irq | input | NUM_EXT | External interrupt lines, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Register select and line index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Request toward the core |
| irq_vec | output | 8 | Vector number of the offered source |
| irq_ack | input | 1 | Core accepts the offered source |
| exc_return | input | 1 | Running handler has finished |
| tail_chain | output | 1 | Acknowledge followed a return directly |

## Verification
Pending and active state change on the edge that captures a stimulus. `irq_req` and `irq_vec` are decoded from that state, so they are valid in the same cycle, after that single edge. `reg_rdata` follows `reg_addr` with no edge at all. `tail_chain` is registered and appears one edge after the chained acknowledge. The bench drives every input just after a falling edge. It reads request and vector at the next falling edge, reads registers a short delay after setting the address, and checks `tail_chain` one cycle after the acknowledge and again one cycle later to show that it falls.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    // Urgency key: smaller is more urgent. Fixed sources sit below every
    // configurable level; the idle level is above everything.
    localparam int          KEY_W    = 5;
    localparam logic [4:0]  KEY_NMI  = 5'd0;
    localparam logic [4:0]  KEY_HF   = 5'd1;
    localparam logic [4:0]  KEY_OFS  = 5'd2;
    localparam logic [4:0]  KEY_IDLE = 5'd31;

    localparam logic [7:0]  VEC_NMI  = 8'd2;
    localparam logic [7:0]  VEC_HF   = 8'd3;
    localparam logic [7:0]  VEC_EXT0 = 8'd16;

    typedef enum logic [1:0] {
        SEL_PRIO = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic logic [KEY_W-1:0] cfg_key(input logic [3:0] p);
        return {1'b0, p} + KEY_OFS;
    endfunction

endpackage

// File: rtl/irq_res_cfg.sv
module irq_res_cfg #(
    parameter int NUM_EXT = 8,
    parameter int IDX_W   = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_prio,
    input  logic                    wr_ctrl,
    input  logic                    wr_mask,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [3:0]              wr_hi,
    input  logic                    wr_en_bit,
    output logic [NUM_EXT-1:0][3:0] prio,
    output logic [NUM_EXT-1:0]      en,
    output logic [3:0]              bmask
);

    typedef struct packed {
        logic [NUM_EXT-1:0][3:0] prio;
        logic [NUM_EXT-1:0]      en;
        logic [3:0]              bmask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int n = 0; n < NUM_EXT; n++) begin
            if (wr_idx == IDX_W'(n)) begin
                if (wr_prio) cfg_d.prio[n] = wr_hi;
                if (wr_ctrl) cfg_d.en[n]   = wr_en_bit;
            end
        end
        if (wr_mask) cfg_d.bmask = wr_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign prio  = cfg_q.prio;
    assign en    = cfg_q.en;
    assign bmask = cfg_q.bmask;

endmodule

// File: rtl/irq_res_pick.sv
module irq_res_pick #(
    parameter int N  = 10,
    parameter int W  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]        cand,
    input  logic [N-1:0][W-1:0] key,
    output logic                found,
    output logic [IW-1:0]       idx,
    output logic [W-1:0]        best
);

    // Strict compare keeps the lowest index on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || key[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = key[i];
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_res_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int IDX_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_req,
    input  logic               fault_req,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               reg_we,
    input  logic [IDX_W+1:0]   reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq_req,
    output logic [7:0]         irq_vec,
    input  logic               irq_ack,
    input  logic               exc_return,
    output logic               tail_chain
);

    localparam int NSRC = NUM_EXT + 2;   // 0: NMI, 1: hard fault, 2+n: line n
    localparam int IW   = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] act;
        logic            ret;
        logic            tail;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic             unused_wbits;

    assign sel          = reg_sel_e'(reg_addr[IDX_W+1:IDX_W]);
    assign idx          = reg_addr[IDX_W-1:0];
    assign unused_wbits = ^reg_wdata[3:2];

    logic [NUM_EXT-1:0][3:0] cfg_prio;
    logic [NUM_EXT-1:0]      cfg_en;
    logic [3:0]              cfg_bmask;

    irq_res_cfg #(.NUM_EXT(NUM_EXT), .IDX_W(IDX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_prio   (reg_we && sel == SEL_PRIO),
        .wr_ctrl   (reg_we && sel == SEL_CTRL),
        .wr_mask   (reg_we && sel == SEL_MASK),
        .wr_idx    (idx),
        .wr_hi     (reg_wdata[7:4]),
        .wr_en_bit (reg_wdata[0]),
        .prio      (cfg_prio),
        .en        (cfg_en),
        .bmask     (cfg_bmask)
    );

    // Urgency keys and eligibility gates per source
    logic [NSRC-1:0][KEY_W-1:0] key;
    logic [NSRC-1:0]            gate;

    always_comb begin
        key[0]  = KEY_NMI;
        key[1]  = KEY_HF;
        gate[0] = 1'b1;
        gate[1] = 1'b1;
        for (int n = 0; n < NUM_EXT; n++) begin
            key[2+n]  = cfg_key(cfg_prio[n]);
            gate[2+n] = cfg_en[n] && !(cfg_bmask != 4'd0 && cfg_prio[n] >= cfg_bmask);
        end
    end

    logic             win_found, act_found;
    logic [IW-1:0]    win_idx, act_idx;
    logic [KEY_W-1:0] win_best, act_best, exec_key;

    irq_res_pick #(.N(NSRC), .W(KEY_W), .IW(IW)) u_pick_pend (
        .cand  (st_q.pend & ~st_q.act & gate),
        .key   (key),
        .found (win_found),
        .idx   (win_idx),
        .best  (win_best)
    );

    irq_res_pick #(.N(NSRC), .W(KEY_W), .IW(IW)) u_pick_act (
        .cand  (st_q.act),
        .key   (key),
        .found (act_found),
        .idx   (act_idx),
        .best  (act_best)
    );

    assign exec_key   = act_found ? act_best : KEY_IDLE;
    assign irq_req    = win_found && (win_best < exec_key);
    assign irq_vec    = (win_idx < IW'(2)) ? (8'(win_idx) + VEC_NMI)
                                           : (8'(win_idx) - 8'd2 + VEC_EXT0);
    assign tail_chain = st_q.tail;

    logic take;
    assign take = irq_req && irq_ack;

    always_comb begin
        st_d = st_q;
        st_d.pend[0] = st_q.pend[0] | nmi_req;
        st_d.pend[1] = st_q.pend[1] | fault_req;
        for (int n = 0; n < NUM_EXT; n++) begin
            st_d.pend[2+n] = st_q.pend[2+n] | (ext_irq[n] & cfg_en[n]);
            if (reg_we && sel == SEL_CTRL && idx == IDX_W'(n))
                st_d.pend[2+n] = reg_wdata[1];
        end
        if (exc_return && act_found)
            st_d.act[act_idx] = 1'b0;
        if (take) begin
            st_d.pend[win_idx] = 1'b0;
            st_d.act[win_idx]  = 1'b1;
        end
        st_d.ret  = exc_return;
        st_d.tail = take && st_q.ret;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Register read mux
    always_comb begin
        reg_rdata = 8'h00;
        case (sel)
            SEL_PRIO: for (int n = 0; n < NUM_EXT; n++)
                          if (idx == IDX_W'(n)) reg_rdata = {cfg_prio[n], 4'h0};
            SEL_CTRL: for (int n = 0; n < NUM_EXT; n++)
                          if (idx == IDX_W'(n))
                              reg_rdata = {5'b0, st_q.act[2+n], st_q.pend[2+n], cfg_en[n]};
            SEL_MASK: reg_rdata = {cfg_bmask, 4'h0};
            default:  reg_rdata = 8'h00;
        endcase
    end

    // R8
    take_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (st_q.act[$past(win_idx)] && !st_q.pend[$past(win_idx)]));

    // R4
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend[0] && !st_q.act[0]) |-> (irq_req && irq_vec == VEC_NMI));

    // R7
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vec >= VEC_EXT0 && cfg_bmask != 4'd0)
            |-> (cfg_prio[win_idx - IW'(2)] < cfg_bmask));

    // R9
    return_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && act_found) |=> !st_q.act[$past(act_idx)]);

    // R10
    tail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_chain |-> ($past(irq_req && irq_ack) && $past(exc_return, 2)));

endmodule

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_EXT    = 8;
    localparam int IDX_W      = 7;
    localparam int WATCHDOG   = 20000;

    localparam logic [1:0] S_PRIO = 2'd0;
    localparam logic [1:0] S_CTRL = 2'd1;
    localparam logic [1:0] S_MASK = 2'd2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               nmi_req = 1'b0;
    logic               fault_req = 1'b0;
    logic [NUM_EXT-1:0] ext_irq = '0;
    logic               reg_we = 1'b0;
    logic [IDX_W+1:0]   reg_addr = '0;
    logic [7:0]         reg_wdata = '0;
    logic [7:0]         reg_rdata;
    logic               irq_req;
    logic [7:0]         irq_vec;
    logic               irq_ack = 1'b0;
    logic               exc_return = 1'b0;
    logic               tail_chain;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    irq_prio_resolver #(.NUM_EXT(NUM_EXT), .IDX_W(IDX_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_req    (nmi_req),
        .fault_req  (fault_req),
        .ext_irq    (ext_irq),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .irq_ack    (irq_ack),
        .exc_return (exc_return),
        .tail_chain (tail_chain)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycle %0d expected finish before %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input int i, input logic [7:0] d);
        reg_we    = 1'b1;
        reg_addr  = {s, IDX_W'(i)};
        reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input int i, output logic [7:0] v);
        reg_addr = {s, IDX_W'(i)};
        #1;
        v = reg_rdata;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic ret_once();
        exc_return = 1'b1;
        step();
        exc_return = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq_req", int'(irq_req), 0);
        chk("R1 tail_chain", int'(tail_chain), 0);
        rd(S_PRIO, 0, v); chk("R1 prio0", int'(v), 0);
        rd(S_CTRL, 0, v); chk("R1 ctrl0", int'(v), 0);
        rd(S_MASK, 0, v); chk("R1 mask", int'(v), 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(S_PRIO, 3, 8'hAB);
        rd(S_PRIO, 3, v); chk("R2 prio low nibble", int'(v), 8'hA0);
        wr(S_MASK, 0, 8'h5F);
        rd(S_MASK, 0, v); chk("R2 mask low nibble", int'(v), 8'h50);
        wr(S_MASK, 0, 8'h00);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        wr(S_CTRL, 3, 8'h01);
        ext_irq[3] = 1'b1;
        step();
        chk("R3 req", int'(irq_req), 1);
        chk("R3 vec", int'(irq_vec), 19);
        rd(S_CTRL, 3, v); chk("R11 ctrl pending+enable", int'(v), 8'h03);
        ext_irq[5] = 1'b1;
        step();
        rd(S_CTRL, 5, v); chk("R3 disabled line not pending", int'(v), 0);
        ext_irq[5] = 1'b0;
        irq_ack = 1'b1;
        ext_irq[3] = 1'b0;
        step();
        irq_ack = 1'b0;
        rd(S_CTRL, 3, v); chk("R8 ack -> active", int'(v), 8'h05);
        chk("R8 req drops", int'(irq_req), 0);
        chk("R10 no tail without return", int'(tail_chain), 0);
        ack_once();
        rd(S_CTRL, 3, v); chk("R8 stray ack ignored", int'(v), 8'h05);
        ret_once();
        rd(S_CTRL, 3, v); chk("R9 return clears active", int'(v), 8'h01);
        wr(S_CTRL, 3, 8'h00);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        wr(S_PRIO, 1, 8'h80);
        wr(S_PRIO, 2, 8'h30);
        wr(S_CTRL, 1, 8'h03);
        wr(S_CTRL, 2, 8'h03);
        chk("R5 lower prio wins vec", int'(irq_vec), 18);
        wr(S_PRIO, 1, 8'h30);
        chk("R5 tie lowest number", int'(irq_vec), 17);
        ack_once();
        chk("R6 equal no preempt", int'(irq_req), 0);
        wr(S_PRIO, 4, 8'h10);
        wr(S_CTRL, 4, 8'h03);
        chk("R6 strictly lower preempts", int'(irq_req), 1);
        chk("R6 preempt vec", int'(irq_vec), 20);
        ack_once();
        rd(S_CTRL, 4, v); chk("R8 nested active", int'(v), 8'h05);
        ret_once();
        rd(S_CTRL, 4, v); chk("R9 inner cleared", int'(v), 8'h01);
        rd(S_CTRL, 1, v); chk("R9 outer still active", int'(v), 8'h05);
        chk("R9 outer level blocks equal", int'(irq_req), 0);
        exc_return = 1'b1;
        step();
        exc_return = 1'b0;
        chk("R9 chained req", int'(irq_req), 1);
        chk("R9 chained vec", int'(irq_vec), 18);
        ack_once();
        chk("R10 tail pulse", int'(tail_chain), 1);
        step();
        chk("R10 tail one cycle", int'(tail_chain), 0);
        ret_once();
        wr(S_CTRL, 1, 8'h00);
        wr(S_CTRL, 2, 8'h00);
        wr(S_CTRL, 4, 8'h00);
    endtask

    task automatic t_mask();
        wr(S_PRIO, 6, 8'h50);
        wr(S_PRIO, 7, 8'h40);
        wr(S_MASK, 0, 8'h40);
        wr(S_CTRL, 6, 8'h03);
        wr(S_CTRL, 7, 8'h03);
        chk("R7 mask blocks equal and above", int'(irq_req), 0);
        wr(S_MASK, 0, 8'h50);
        chk("R7 below mask passes", int'(irq_req), 1);
        chk("R7 below mask vec", int'(irq_vec), 23);
        wr(S_MASK, 0, 8'h40);
        nmi_req   = 1'b1;
        fault_req = 1'b1;
        step();
        nmi_req   = 1'b0;
        fault_req = 1'b0;
        chk("R4 nmi unmasked req", int'(irq_req), 1);
        chk("R4 nmi vec first", int'(irq_vec), 2);
        ack_once();
        chk("R4 fault waits under nmi", int'(irq_req), 0);
        ret_once();
        chk("R7 fault unmasked req", int'(irq_req), 1);
        chk("R4 fault vec", int'(irq_vec), 3);
        ack_once();
        ret_once();
        chk("R7 masked after faults", int'(irq_req), 0);
        wr(S_MASK, 0, 8'h00);
        chk("R7 zero mask req", int'(irq_req), 1);
        chk("R7 zero mask vec", int'(irq_vec), 23);
    endtask

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_ext();
        t_prio();
        t_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule